// File: doc/BRIEF.md
# Serial Control Register Write Slave

This block is a two-wire serial slave that lets a bus master program a bank of 256 eight-bit control registers. A faster system clock samples SCL and SDA. The block finds start and stop conditions and checks the first byte of a transfer against a configured 7-bit device identifier. It takes the second byte as a register pointer. Every byte after that is written to the register the pointer selects, and the pointer then moves on by one. One transfer can therefore fill a run of neighbouring registers.

SDA is only ever pulled low, through an output enable, to acknowledge a byte. For every stored byte the block gives a one-cycle write strobe together with the target address and the data. The register contents are available to the rest of the chip on a combinational read port. Read transfers, clock stretching and arbitration between masters are not handled. A transfer whose direction bit is set gets no acknowledge.

Top module: `regwr_slave`

## Requirements
- R1: After reset `sda_oe_o` and `wr_en_o` are 0 and every register reads 0.
- R2: An SDA fall while SCL is high is a start condition. An SDA rise while SCL is high is a stop condition. After a stop, bytes sent without a new start get no acknowledge and write nothing.
- R3: The first byte after a start is sent MSB first and holds the 7-bit device ID in bits 7..1 and the direction bit in bit 0. When the ID matches `DEV_ID` and the direction bit is 0, `sda_oe_o` is 1 while SCL is high in the ninth bit slot.
- R4: When the ID does not match, or the direction bit is 1, `sda_oe_o` stays 0 in the acknowledge slot. Later bytes are neither acknowledged nor written until the next start.
- R5: The second byte of a write transfer is acknowledged and loads the register pointer.
- R6: Each later byte produces exactly one `wr_en_o` pulse, one system clock long, with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte. The pulse comes after the eighth bit is sampled and before the acknowledge slot. The byte is acknowledged.
- R7: After each data byte the pointer increments by one, so consecutive data bytes land at consecutive addresses.
- R8: The pointer wraps from 0xFF to 0x00.
- R9: A repeated start inside a partly received data byte writes nothing for that byte and restarts ID reception. The transfer that follows then works normally.
- R10: `sda_oe_o` returns to 0 on the SCL falling edge that ends the acknowledge slot.
- R11: `rd_data_o` shows the register selected by `rd_addr_i`, which holds the last byte written there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register address of the write |
| wr_data_o | output | 8 | Byte being written |
| rd_addr_i | input | 8 | Register read select |
| rd_data_o | output | 8 | Selected register contents |

## Verification
Each bus line passes through two synchronizing flops and an edge register, and the control logic adds one more stage. So `wr_en_o` rises three system clocks after the eighth SCL rising edge reaches the pin. `sda_oe_o` rises or falls three clocks after the matching SCL falling edge. The bench holds every SCL phase for sixteen system clocks. It samples the acknowledge in the middle of the ninth high phase, and it samples the release eight clocks into the following low phase, well clear of those latencies. A monitor pops the expected address and data at each strobe. The bench confirms that the expected queue is empty before the acknowledge, which shows the write came first.

// File: rtl/regwr_pkg.sv
package regwr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK_WAIT,
    ST_ACK,
    ST_IGNORE
  } rx_state_e;

  typedef enum logic [1:0] {
    PH_ID,
    PH_SUB,
    PH_DATA
  } rx_phase_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;  // idle bus is high
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import regwr_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'h21,
  parameter int         ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  rx_state_e         state_q;
  rx_phase_e         phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] nxt_byte;
  logic [ADDR_W-1:0] ptr_q;
  logic              start_evt, stop_evt, last_bit;

  assign start_evt = sda_fall_i & scl_lvl_i;
  assign stop_evt  = sda_rise_i & scl_lvl_i;
  assign nxt_byte  = {shreg_q[BYTE_W-2:0], sda_lvl_i};
  assign last_bit  = (cnt_q == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ID;
      cnt_q     <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_evt) begin
        state_q  <= ST_RECV;
        phase_q  <= PH_ID;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_evt) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RECV: if (scl_rise_i) begin
            shreg_q <= nxt_byte;
            cnt_q   <= cnt_q + 1'b1;
            if (last_bit) begin
              unique case (phase_q)
                PH_ID: state_q <= (nxt_byte[7:1] == DEV_ID && !nxt_byte[0])
                                  ? ST_ACK_WAIT : ST_IGNORE;
                PH_SUB: begin
                  ptr_q   <= nxt_byte[ADDR_W-1:0];
                  state_q <= ST_ACK_WAIT;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr_q;
                  wr_data_o <= nxt_byte;
                  ptr_q     <= ptr_q + 1'b1;
                  state_q   <= ST_ACK_WAIT;
                end
              endcase
            end
          end
          ST_ACK_WAIT: if (scl_fall_i) begin
            sda_oe_o <= 1'b1;
            state_q  <= ST_ACK;
          end
          ST_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_RECV;
            cnt_q    <= '0;
            phase_q  <= (phase_q == PH_ID) ? PH_SUB : PH_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o); // R6
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ptr_q == ADDR_W'(wr_addr_o + 1'b1)); // R7
  AST_NO_ACK_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IGNORE |-> !sda_oe_o); // R4
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> state_q == ST_IDLE && !sda_oe_o); // R2
  AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && scl_fall_i && !start_evt && !stop_evt) |=> !sda_oe_o); // R10
  AST_START_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> !wr_en_o && state_q == ST_RECV); // R9
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  AST_BANK_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i)); // R11
endmodule

// File: rtl/regwr_slave.sv
module regwr_slave
  import regwr_pkg::*;
#(
  parameter logic [6:0] DEV_ID      = 7'h21,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] pin, lvl, rise, fall;
  assign pin = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .d_i     (pin[g]),
      .level_o (lvl[g]),
      .rise_o  (rise[g]),
      .fall_o  (fall[g])
    );
  end

  rx_ctrl #(.DEV_ID(DEV_ID), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_lvl_i  (lvl[0]),
    .scl_rise_i (rise[0]),
    .scl_fall_i (fall[0]),
    .sda_lvl_i  (lvl[1]),
    .sda_rise_i (rise[1]),
    .sda_fall_i (fall[1]),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  reg_bank #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_o),
    .wr_addr_i (wr_addr_o),
    .wr_data_i (wr_data_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: tb/regwr_slave_tb_top.sv
module regwr_slave_tb_top;
  localparam int HALF = 16;
  localparam logic [7:0] ID_WR = 8'h42;  // ID 0x21, direction 0

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_line;
  logic sda_oe, wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  int n_checks = 0;
  int n_errors = 0;
  logic [15:0] exp_q[$];
  logic [7:0] model [256];
  logic [7:0] tb_ptr;

  always #2 clk = ~clk;  // 250 MHz

  assign sda_line = sda_drv & ~sda_oe;

  regwr_slave dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 R9 unexpected write", {wr_addr, wr_data}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} == e, "R6 R7 R8 write addr/data", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic bus_start();
    sda_drv = 1'b1; wait_clk(HALF);
    scl = 1'b1;     wait_clk(HALF);
    sda_drv = 1'b0; wait_clk(HALF);
    scl = 1'b0;     wait_clk(HALF);
  endtask

  task automatic bus_stop();
    scl = 1'b0;     wait_clk(HALF);
    sda_drv = 1'b0; wait_clk(HALF);
    scl = 1'b1;     wait_clk(HALF);
    sda_drv = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    scl = 1'b0; wait_clk(HALF);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_drv = b[i]; wait_clk(HALF);
      scl = 1'b1;     wait_clk(HALF);
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit chk_wr,
                           input string req);
    send_bits(b, 8);
    sda_drv = 1'b1; wait_clk(HALF);
    scl = 1'b1;     wait_clk(HALF / 2);
    check(sda_oe == exp_ack, req, sda_oe, exp_ack);
    if (chk_wr) check(exp_q.size() == 0, "R6 strobe before ack", exp_q.size(), 0);
    wait_clk(HALF / 2);
    scl = 1'b0;     wait_clk(HALF / 2);
    check(sda_oe == 1'b0, "R10 release after ack", sda_oe, 0);
    wait_clk(HALF / 2);
  endtask

  task automatic send_data(input logic [7:0] b);
    exp_q.push_back({tb_ptr, b});
    model[tb_ptr] = b;
    send_byte(b, 1'b1, 1'b1, "R6 data ack");
    tb_ptr = tb_ptr + 8'd1;
  endtask

  task automatic open_write(input logic [7:0] sub);
    bus_start();
    send_byte(ID_WR, 1'b1, 1'b0, "R3 id ack");
    send_byte(sub, 1'b1, 1'b0, "R5 sub-address ack");
    tb_ptr = sub;
  endtask

  task automatic read_reg(input logic [7:0] a, input logic [7:0] e, input string req);
    rd_addr = a; wait_clk(1);
    check(rd_data == e, req, rd_data, e);
  endtask

  initial begin
    rd_addr = 8'h00;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    wait_clk(5);
    // R1 reset state
    check(sda_oe == 1'b0, "R1 oe at reset", sda_oe, 0);
    check(wr_en == 1'b0, "R1 strobe at reset", wr_en, 0);
    read_reg(8'h10, 8'h00, "R1 register cleared");
    rst_n = 1'b1;
    wait_clk(HALF);

    // R3 R5 R6 single write
    open_write(8'h10);
    send_data(8'hA5);
    bus_stop();
    check(exp_q.size() == 0, "R6 single write done", exp_q.size(), 0);

    // R7 burst
    open_write(8'h20);
    send_data(8'h11);
    send_data(8'h22);
    send_data(8'h33);
    bus_stop();
    check(exp_q.size() == 0, "R7 burst done", exp_q.size(), 0);

    // R8 wrap
    open_write(8'hFE);
    send_data(8'h01);
    send_data(8'h02);
    send_data(8'h03);
    bus_stop();
    read_reg(8'h00, 8'h03, "R8 wrapped to 0x00");

    // R4 wrong ID
    bus_start();
    send_byte(8'h40, 1'b0, 1'b0, "R4 wrong id no ack");
    send_byte(8'h30, 1'b0, 1'b0, "R4 ignored byte no ack");
    send_byte(8'h99, 1'b0, 1'b0, "R4 ignored byte no ack");
    bus_stop();
    read_reg(8'h30, 8'h00, "R4 no write after wrong id");

    // R4 read direction
    bus_start();
    send_byte(8'h43, 1'b0, 1'b0, "R4 read direction no ack");
    send_byte(8'h31, 1'b0, 1'b0, "R4 ignored byte no ack");
    bus_stop();
    read_reg(8'h31, 8'h00, "R4 no write after read id");

    // R2 bytes after stop without start
    send_byte(ID_WR, 1'b0, 1'b0, "R2 no ack after stop");
    send_byte(8'h32, 1'b0, 1'b0, "R2 no ack after stop");
    bus_stop();

    // R9 repeated start mid data byte
    open_write(8'h40);
    send_data(8'h77);
    send_bits(8'hC3, 4);
    bus_start();
    send_byte(ID_WR, 1'b1, 1'b0, "R9 id ack after repeated start");
    send_byte(8'h50, 1'b1, 1'b0, "R9 sub-address ack");
    tb_ptr = 8'h50;
    send_data(8'h88);
    bus_stop();
    read_reg(8'h41, 8'h00, "R9 partial byte not written");
    read_reg(8'h50, 8'h88, "R9 write after repeated start");

    // R11 full read-back
    for (int a = 0; a < 256; a++) read_reg(a[7:0], model[a], "R11 read port contents");
    check(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule